// File: doc/BRIEF.md
# Windowed Request-to-Response Delay Monitor

This block watches a request line and a response line and judges every request on its own. A request sampled high on a rising clock edge opens an attempt. The attempt owns one thread for each allowed delay from `MIN_DLY` to `MAX_DLY` clock edges. A thread matches when the response is high on exactly the edge it was scheduled for. Delays count sampled clock edges only. A delay of one means the next edge. A delay of zero means the same edge as the request.

An attempt ends on the edge where its longest thread, at delay `MAX_DLY`, is due. On that edge the monitor gives one registered verdict. If any thread matched, the verdict is a pass, together with the number of matches. If several threads matched, the multi-match flag is also raised. If no thread matched, the verdict is a fail, so a response that never comes becomes a visible timeout. Requests that overlap are tracked in separate slots and do not affect one another.

The block is placed next to a handshake inside a design, or in an emulation build, to catch responses that arrive early, late or never.

Top module: `rsp_win_mon`

## Requirements
- R1: A request sampled at edge t is judged on edge t+MAX_DLY. Its verdict is on the outputs for exactly the one clock cycle that follows that edge.
- R2: An attempt passes when the response is high on at least one edge t+d with MIN_DLY <= d <= MAX_DLY. In that case `pass` is 1 and `fail` is 0 for that cycle.
- R3: An attempt with no response inside its window raises `fail` for that cycle, with `match_cnt` = 0. A missing response therefore always produces a fail and is never silently dropped.
- R4: A response on an edge outside the window does not count toward the attempt. When MIN_DLY = MAX_DLY, a response one edge early fails, just as a late one does.
- R5: `match_cnt` gives the number of window edges on which the response was high. `multi_match` is 1 exactly when that number is 2 or more, and it is raised only together with `pass`.
- R6: When MIN_DLY = 0, a response high on the same edge as the request is a match.
- R7: Overlapping attempts are judged independently. With the default SLOTS = MAX_DLY+1, a request on every edge is tracked without any request being lost.
- R8: `pass` and `fail` are never both high. On cycles that carry no verdict, `pass`, `fail` and `multi_match` are 0 and `match_cnt` is 0.
- R9: `rst_n` low at an edge is a synchronous reset. It discards all pending attempts, and all outputs read 0 in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; every delay is counted in its rising edges |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request; opens one attempt on each edge where it is high |
| rsp | input | 1 | Response observed by the pending threads |
| pass | output | 1 | One-cycle pulse: the attempt being judged had at least one match |
| fail | output | 1 | One-cycle pulse: the attempt being judged had no match |
| multi_match | output | 1 | One-cycle pulse: the attempt being judged had two or more matches |
| match_cnt | output | $clog2(MAX_DLY+2) | Number of matches of the attempt being judged, 0 when no verdict is given |

## Verification
The hardest situation to reach from the ports is every slot busy at once. In that state, one attempt is judged on the same edge that a new attempt takes a slot, and each pending attempt sees a different part of the same response stream. The stimulus drives a stretch with the request high on every edge and a random response, which fills all MAX_DLY+1 slots and forces a slot to be reused on the edge it is freed. Three instances share one stimulus stream: a wide window, a fixed delay and a window that starts at zero. The same response edges are therefore judged as early, on time or same-edge, depending on the instance.

// File: rtl/rsp_win_pkg.sv
package rsp_win_pkg;

  // Width of a match counter able to hold MAX+1 hits.
  function automatic int unsigned cnt_bits(input int unsigned max_dly);
    return $clog2(max_dly + 2);
  endfunction

  // True when a delay of d edges lies inside the window [lo:hi].
  function automatic bit in_window(input int unsigned d, input int unsigned lo,
                                   input int unsigned hi);
    return (d >= lo) && (d <= hi);
  endfunction

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

endpackage

// File: rtl/rsp_win_alloc.sv
// Hands a new request to the lowest-numbered idle slot.
module rsp_win_alloc #(
  parameter int SLOTS = 4
) (
  input  logic             req,
  input  logic [SLOTS-1:0] busy,
  output logic [SLOTS-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (req && !busy[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsp_win_slot.sv
// One attempt: a vector of pending delay threads plus a hit counter.
// Bit k of the pending vector is the thread due k edges from now.
module rsp_win_slot
  import rsp_win_pkg::*;
#(
  parameter int MIN_DLY = 1,
  parameter int MAX_DLY = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rsp,
  output logic             busy,
  output logic             resolve,
  output logic [CNT_W-1:0] total
);
  localparam int W = MAX_DLY + 1;

  function automatic logic [W-1:0] window_mask();
    logic [W-1:0] m;
    m = '0;
    for (int k = 0; k < W; k++) begin
      if (in_window(k, MIN_DLY, MAX_DLY)) m[k] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [W-1:0] WIN = window_mask();

  logic [W-1:0]     pend_q;
  logic [W-1:0]     cur;
  logic [W-1:0]     rem;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic             active;
  logic             due;
  logic             hit;

  assign busy   = |pend_q;
  assign active = start | busy;
  assign cur    = start ? WIN : pend_q;
  assign base   = start ? '0 : cnt_q;
  assign due    = cur[0];
  assign rem    = cur >> 1;
  assign hit    = active & due & rsp;
  assign total  = base + CNT_W'(hit);
  // The last thread (delay MAX) is due when nothing remains after it.
  assign resolve = active & (rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (resolve) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (active) begin
      pend_q <= rem;
      cnt_q  <= total;
    end
  end
endmodule

// File: rtl/rsp_win_merge.sv
// Selects the result of the slot being judged; at most one per edge.
module rsp_win_merge #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 4
) (
  input  logic [SLOTS-1:0]            resolve,
  input  logic [SLOTS-1:0][CNT_W-1:0] totals,
  output logic                        any_res,
  output logic [CNT_W-1:0]            sel_total
);
  always_comb begin
    sel_total = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (resolve[i]) sel_total = sel_total | totals[i];
    end
  end
  assign any_res = |resolve;
endmodule

// File: rtl/rsp_win_mon.sv
module rsp_win_mon
  import rsp_win_pkg::*;
#(
  parameter int MIN_DLY = 1,
  parameter int MAX_DLY = 8,
  parameter int SLOTS   = MAX_DLY + 1,
  parameter int CNT_W   = cnt_bits(MAX_DLY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             rsp,
  output logic             pass,
  output logic             fail,
  output logic             multi_match,
  output logic [CNT_W-1:0] match_cnt
);
  // Named internal events, observed by the bound checker.
  logic [SLOTS-1:0]            slot_busy;
  logic [SLOTS-1:0]            slot_start;
  logic [SLOTS-1:0]            slot_resolve;
  logic [SLOTS-1:0][CNT_W-1:0] slot_total;
  logic                        res_any;
  logic [CNT_W-1:0]            res_total;
  verdict_e                    verdict;

  rsp_win_alloc #(.SLOTS(SLOTS)) u_alloc (
    .req  (req),
    .busy (slot_busy),
    .grant(slot_start)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    rsp_win_slot #(
      .MIN_DLY(MIN_DLY),
      .MAX_DLY(MAX_DLY),
      .CNT_W  (CNT_W)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (slot_start[s]),
      .rsp    (rsp),
      .busy   (slot_busy[s]),
      .resolve(slot_resolve[s]),
      .total  (slot_total[s])
    );
  end

  rsp_win_merge #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_merge (
    .resolve  (slot_resolve),
    .totals   (slot_total),
    .any_res  (res_any),
    .sel_total(res_total)
  );

  always_comb begin
    if (!res_any)              verdict = VERDICT_NONE;
    else if (res_total != '0)  verdict = VERDICT_PASS;
    else                       verdict = VERDICT_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass        <= 1'b0;
      fail        <= 1'b0;
      multi_match <= 1'b0;
      match_cnt   <= '0;
    end else begin
      pass        <= (verdict == VERDICT_PASS);
      fail        <= (verdict == VERDICT_FAIL);
      multi_match <= (verdict == VERDICT_PASS) && (res_total >= CNT_W'(2));
      match_cnt   <= res_any ? res_total : '0;
    end
  end
endmodule

// File: rtl/rsp_win_chk.sv
module rsp_win_chk #(
  parameter int SLOTS   = 4,
  parameter int MAX_DLY = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             pass,
  input logic             fail,
  input logic             multi_match,
  input logic [CNT_W-1:0] match_cnt,
  input logic [SLOTS-1:0] slot_busy,
  input logic [SLOTS-1:0] slot_start,
  input logic [SLOTS-1:0] slot_resolve
);
  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_multi_needs_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    multi_match |-> (pass && match_cnt >= CNT_W'(2)));

  assert_fail_no_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (match_cnt == '0));

  assert_pass_has_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (match_cnt != '0));

  assert_single_resolve_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_resolve));

  assert_start_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_start));

  assert_verdict_after_resolve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> $past(|slot_resolve));

  if (SLOTS > MAX_DLY) begin : g_cap
    assert_req_gets_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (slot_start != '0));
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= !rst_n;

  always @(posedge clk) begin
    if (rst_d == 1'b1) begin
      assert_reset_clears_R9: assert (!pass && !fail && !multi_match && slot_busy == '0);
    end
  end
endmodule

bind rsp_win_mon rsp_win_chk #(
  .SLOTS  (SLOTS),
  .MAX_DLY(MAX_DLY),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .pass        (pass),
  .fail        (fail),
  .multi_match (multi_match),
  .match_cnt   (match_cnt),
  .slot_busy   (slot_busy),
  .slot_start  (slot_start),
  .slot_resolve(slot_resolve)
);

// File: tb/tb_rsp_win_mon.sv
`timescale 1ns/1ps
module tb_rsp_win_mon;
  import rsp_win_pkg::*;

  localparam int NE     = 3010;
  localparam int RST2   = 2000;
  localparam int W_WIDE = cnt_bits(8);
  localparam int W_FIX  = cnt_bits(3);
  localparam int W_ZERO = cnt_bits(2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic rsp = 1'b0;

  logic p0, f0, m0, p1, f1, m1, p2, f2, m2;
  logic [W_WIDE-1:0] c0;
  logic [W_FIX-1:0]  c1;
  logic [W_ZERO-1:0] c2;

  bit hreq [0:NE];
  bit hrsp [0:NE];
  int last_rst;
  int vecs = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsp_win_mon #(.MIN_DLY(1), .MAX_DLY(8)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rsp(rsp),
    .pass(p0), .fail(f0), .multi_match(m0), .match_cnt(c0));

  rsp_win_mon #(.MIN_DLY(3), .MAX_DLY(3)) dut_fix (
    .clk(clk), .rst_n(rst_n), .req(req), .rsp(rsp),
    .pass(p1), .fail(f1), .multi_match(m1), .match_cnt(c1));

  rsp_win_mon #(.MIN_DLY(0), .MAX_DLY(2)) dut_zero (
    .clk(clk), .rst_n(rst_n), .req(req), .rsp(rsp),
    .pass(p2), .fail(f2), .multi_match(m2), .match_cnt(c2));

  // Expected verdict after edge e for a window [lo:hi].
  task automatic model(input int e, input int lo, input int hi,
                       output bit ep, output bit ef, output bit em, output int ec);
    int a;
    a  = e - hi;
    ep = 0; ef = 0; em = 0; ec = 0;
    if (a >= 1 && a > last_rst && hreq[a]) begin
      for (int d = lo; d <= hi; d++) ec += int'(hrsp[a + d]);
      ep = (ec > 0);
      ef = (ec == 0);
      em = (ec >= 2);
    end
  endtask

  function automatic string tag_of(int e, int lo, int hi, bit ep, bit ef, bit em);
    if (e <= 3 || (e >= RST2 && e <= RST2 + hi)) return "R9";
    if (ef) return (lo == hi) ? "R4 R3" : "R3 R1";
    if (em) return "R5";
    if (ep && lo == 0 && hrsp[e - hi]) return "R6";
    if (ep) return (e > 1500 && e <= 1720) ? "R7 R2" : "R2 R1";
    return "R8";
  endfunction

  task automatic cmp(string who, string tag, logic p, logic f, logic m, int c,
                     bit ep, bit ef, bit em, int ec);
    vecs++;
    if (p !== ep || f !== ef || m !== em || c != ec) begin
      bad++;
      $display("FAIL %s %s at %0t: got pass=%0b fail=%0b multi=%0b cnt=%0d, expected pass=%0b fail=%0b multi=%0b cnt=%0d",
               tag, who, $time, p, f, m, c, ep, ef, em, ec);
    end
  endtask

  initial begin
    void'($urandom(32'd20240));
    last_rst = 3;
    @(negedge clk);
    for (int e = 1; e <= NE; e++) begin
      bit r, s, rs;
      bit ep, ef, em;
      int ec;
      if (e <= 40) begin
        r = (e % 12 == 4); s = (e % 12 == 6);          // +2: early for the fixed window
      end else if (e <= 80) begin
        r = (e % 12 == 5); s = (e % 12 == 8);          // +3: exact for the fixed window
      end else if (e <= 120) begin
        r = (e % 12 == 9); s = (e % 12 >= 9 && e % 12 <= 11); // +0,+1,+2
      end else if (e > 1500 && e <= 1710) begin
        r = 1'b1; s = ($urandom % 2) == 0;             // all slots busy
      end else if (e <= 3000) begin
        r = ($urandom % 10) < 3; s = ($urandom % 10) < 4;
      end else begin
        r = 1'b0; s = 1'b0;
      end
      rs = !(e <= 3 || e == RST2);
      if (!rs) last_rst = e;
      rst_n = rs; req = r; rsp = s;
      hreq[e] = r; hrsp[e] = s;
      @(posedge clk);
      @(negedge clk);
      model(e, 1, 8, ep, ef, em, ec);
      cmp("wide", tag_of(e, 1, 8, ep, ef, em), p0, f0, m0, int'(c0), ep, ef, em, ec);
      model(e, 3, 3, ep, ef, em, ec);
      cmp("fixed", tag_of(e, 3, 3, ep, ef, em), p1, f1, m1, int'(c1), ep, ef, em, ec);
      model(e, 0, 2, ep, ef, em, ec);
      cmp("zero", tag_of(e, 0, 2, ep, ef, em), p2, f2, m2, int'(c2), ep, ef, em, ec);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule